// File: doc/BRIEF.md
# DMA Channel Control and Request Front End

This block holds the control word for one DMA channel and decides when the channel's datapath may move data. Software writes a single 32-bit control word through a write/read port. A start bit in that word arms the channel. The other fields set two interrupt enables, the byte order passed to the datapath, and how transfer requests reach the channel.

The channel has three states: idle, ready and active. An armed channel waits in ready until a request arrives. It then gives a one-cycle `xfer_go` pulse to the datapath and becomes active (busy). The request can come from software, in which case the start write itself is the request. It can also come from an external request line, which passes through a synchronizer and can be detected by level or by edge, with either polarity.

The datapath reports the end of a transfer with a `xfer_done` or `xfer_err` strobe. The channel then returns to idle and, if the matching enable is set, raises a sticky interrupt flag. Software clears that flag through its own clear input.

Top module: `dma_chan_ctrl`

## Requirements
- R1: Control bit 0 is the start bit. Writing 1 to it while the channel is idle moves the channel to ready at the write edge. Writing 0, or writing 1 while the channel is ready or active, leaves the channel state unchanged. Bit 0 always reads as 0.
- R2: After reset the control word reads 0x0000000E: done enable = 1, error enable = 1, big-endian = 1, and external mode, polarity and level = 0. At the same time `xfer_go`, `busy`, `irq_done` and `irq_err` are 0.
- R3: The control word has these fields. Bit 1 is the done-interrupt enable. Bit 2 is the error-interrupt enable. Bit 3 selects big-endian. Bit 4 selects external request mode. Bit 5 is the polarity (1 = active high, 0 = active low). Bit 6 selects level (1) or edge (0) detection. These fields read back what was written. Bits 31:7 read as 0 and ignore written data.
- R4: In software mode (bit 4 = 0), `xfer_go` is high for exactly the first cycle the channel spends in ready. From the next edge on, `busy` is 1.
- R5: In external edge mode, `ext_req` passes through two flip-flops. `xfer_go` rises in the cycle after the second clock edge that follows an active-going transition, and it lasts one cycle. If such a transition happens while the channel is not ready, no request is recorded for it.
- R6: In external level mode, `xfer_go` is high in any ready cycle in which the synchronized request is at its active level. Re-arming with the request held active gives a pulse immediately.
- R7: In external mode, a request at the inactive level for the selected polarity never produces `xfer_go`. In software mode, the polarity and level bits and `ext_req` have no effect.
- R8: A `xfer_done` strobe with `xfer_err` low in the active state returns the channel to idle. It sets `irq_done` when bit 1 is 1 and leaves it unchanged when bit 1 is 0.
- R9: A `xfer_err` strobe in the active state returns the channel to idle. It sets `irq_err` when bit 2 is 1. If `xfer_done` arrives in the same cycle, only the error counts and `irq_done` is not set.
- R10: `xfer_done` and `xfer_err` strobes outside the active state are ignored: they change neither the state nor the interrupt flags.
- R11: Each interrupt flag stays set until a cycle with its clear input high. If the flag is set by a new event in the same cycle as its clear, the set wins.
- R12: The output `big_endian` always equals control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Control word read data |
| ext_req | input | 1 | Asynchronous external transfer request |
| xfer_done | input | 1 | Datapath strobe: transfer ended normally |
| xfer_err | input | 1 | Datapath strobe: transfer ended with an error |
| clr_done | input | 1 | Clears the done interrupt flag |
| clr_err | input | 1 | Clears the error interrupt flag |
| xfer_go | output | 1 | One-cycle pulse telling the datapath to start |
| busy | output | 1 | Channel is active |
| big_endian | output | 1 | Byte order for the datapath |
| irq_done | output | 1 | Sticky normal-completion interrupt |
| irq_err | output | 1 | Sticky abnormal-termination interrupt |

## Verification
The single-pulse property of edge detection assumes that the polarity and level bits do not change while a request edge is being detected. The bench changes them only while `ext_req` sits at the new inactive level, then waits several cycles before arming the channel. Completion properties assume that the datapath strobes are one cycle wide. The bench drives every strobe, write and clear for exactly one cycle on the falling edge.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READY  = 2'd1,
        ST_ACTIVE = 2'd2
    } chan_st_e;

    localparam int START_BIT   = 0;
    localparam int DONE_IE_BIT = 1;
    localparam int ERR_IE_BIT  = 2;
    localparam int BIG_BIT     = 3;
    localparam int EXT_BIT     = 4;
    localparam int POL_BIT     = 5;
    localparam int LEV_BIT     = 6;
    localparam int CFG_TOP     = 6;

    typedef struct packed {
        logic lev;
        logic pol;
        logic ext;
        logic big;
        logic err_ie;
        logic done_ie;
    } cfg_t;
endpackage

// File: rtl/dcc_cfg_reg.sv
module dcc_cfg_reg
    import dcc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              start_wr,
    output cfg_t              cfg
);
    localparam int PAD_W = DATA_W - CFG_TOP - 1;
    localparam cfg_t CFG_RST = '{lev: 1'b0, pol: 1'b0, ext: 1'b0,
                                 big: 1'b1, err_ie: 1'b1, done_ie: 1'b1};

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.done_ie = wr_data[DONE_IE_BIT];
            cfg_d.err_ie  = wr_data[ERR_IE_BIT];
            cfg_d.big     = wr_data[BIG_BIT];
            cfg_d.ext     = wr_data[EXT_BIT];
            cfg_d.pol     = wr_data[POL_BIT];
            cfg_d.lev     = wr_data[LEV_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign start_wr = wr_en & wr_data[START_BIT];
    assign cfg      = cfg_q;
    assign rd_data  = {{PAD_W{1'b0}}, cfg_q.lev, cfg_q.pol, cfg_q.ext,
                       cfg_q.big, cfg_q.err_ie, cfg_q.done_ie, 1'b0};

    // R3: fields follow the last written value
    assert_cfg_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[CFG_TOP:1] == $past(wr_data[CFG_TOP:1])));
endmodule

// File: rtl/dcc_req_det.sv
module dcc_req_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_req,
    input  logic pol,
    input  logic lev,
    output logic hit
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
    } det_t;

    det_t det_d, det_q;
    logic sync_out, act_now, act_prev;

    assign sync_out = det_q.sync[SYNC_STAGES-1];

    always_comb begin
        det_d      = det_q;
        det_d.sync = {det_q.sync[SYNC_STAGES-2:0], ext_req};
        det_d.last = sync_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign act_now  = pol ? sync_out   : ~sync_out;
    assign act_prev = pol ? det_q.last : ~det_q.last;
    assign hit      = lev ? act_now : (act_now & ~act_prev);

    // R5: one transition yields a single-cycle edge hit
    assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lev && hit) |=> (lev || !hit || !$stable(pol)));
endmodule

// File: rtl/dcc_seq.sv
module dcc_seq
    import dcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic ext_mode,
    input  logic ext_hit,
    input  logic done_ie,
    input  logic err_ie,
    input  logic xfer_done,
    input  logic xfer_err,
    input  logic clr_done,
    input  logic clr_err,
    output logic xfer_go,
    output logic busy,
    output logic irq_done,
    output logic irq_err
);
    typedef struct packed {
        chan_st_e st;
        logic     irq_done;
        logic     irq_err;
    } seq_t;

    seq_t s_d, s_q;
    logic req, fin_ok, fin_bad;

    assign req     = ext_mode ? ext_hit : 1'b1;
    assign fin_ok  = (s_q.st == ST_ACTIVE) && xfer_done && !xfer_err;
    assign fin_bad = (s_q.st == ST_ACTIVE) && xfer_err;

    always_comb begin
        s_d     = s_q;
        xfer_go = 1'b0;
        case (s_q.st)
            ST_IDLE:   if (start_wr) s_d.st = ST_READY;
            ST_READY:  if (req) begin
                           xfer_go = 1'b1;
                           s_d.st  = ST_ACTIVE;
                       end
            ST_ACTIVE: if (xfer_done || xfer_err) s_d.st = ST_IDLE;
            default:   s_d.st = ST_IDLE;
        endcase
        if (clr_done)           s_d.irq_done = 1'b0;
        if (fin_ok && done_ie)  s_d.irq_done = 1'b1;
        if (clr_err)            s_d.irq_err  = 1'b0;
        if (fin_bad && err_ie)  s_d.irq_err  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, irq_done: 1'b0, irq_err: 1'b0};
        else        s_q <= s_d;
    end

    assign busy     = (s_q.st == ST_ACTIVE);
    assign irq_done = s_q.irq_done;
    assign irq_err  = s_q.irq_err;

    assert_ready_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_READY && $past(s_q.st) == ST_IDLE) |-> $past(start_wr));
    assert_go_then_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |=> busy);
    assert_done_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && xfer_done && !xfer_err && done_ie) |=> (irq_done && !busy));
    assert_err_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && xfer_err && err_ie) |=> (irq_err && !busy));
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && !start_wr) |=> (s_q.st == ST_IDLE));
    assert_sticky_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_done && !clr_done) |=> irq_done);
    assert_sticky_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_err && !clr_err) |=> irq_err);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dcc_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ext_req,
    input  logic              xfer_done,
    input  logic              xfer_err,
    input  logic              clr_done,
    input  logic              clr_err,
    output logic              xfer_go,
    output logic              busy,
    output logic              big_endian,
    output logic              irq_done,
    output logic              irq_err
);
    cfg_t cfg;
    logic start_wr, ext_hit;

    dcc_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .start_wr(start_wr), .cfg(cfg)
    );

    dcc_req_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk(clk), .rst_n(rst_n), .ext_req(ext_req),
        .pol(cfg.pol), .lev(cfg.lev), .hit(ext_hit)
    );

    dcc_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .ext_mode(cfg.ext),
        .ext_hit(ext_hit), .done_ie(cfg.done_ie), .err_ie(cfg.err_ie),
        .xfer_done(xfer_done), .xfer_err(xfer_err),
        .clr_done(clr_done), .clr_err(clr_err),
        .xfer_go(xfer_go), .busy(busy), .irq_done(irq_done), .irq_err(irq_err)
    );

    assign big_endian = cfg.big;

    // R12: byte order output tracks the written field
    assert_big_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (big_endian == $past(wr_data[BIG_BIT])));
endmodule

// File: tb/sim_dma_chan_ctrl.sv
module sim_dma_chan_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ext_req = 1'b0;
    logic        xfer_done = 1'b0, xfer_err = 1'b0;
    logic        clr_done = 1'b0, clr_err = 1'b0;
    logic        xfer_go, busy, big_endian, irq_done, irq_err;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dma_chan_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ext_req(ext_req), .xfer_done(xfer_done),
        .xfer_err(xfer_err), .clr_done(clr_done), .clr_err(clr_err),
        .xfer_go(xfer_go), .busy(busy), .big_endian(big_endian),
        .irq_done(irq_done), .irq_err(irq_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input bit de, ee, big, ext, pol, lev, st);
        return {25'd0, lev, pol, ext, big, ee, de, st};
    endfunction

    task automatic wr(input logic [31:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic strobe(input bit d, input bit e, input bit cd, input bit ce);
        @(negedge clk); xfer_done = d; xfer_err = e; clr_done = cd; clr_err = ce;
        @(negedge clk); xfer_done = 0; xfer_err = 0; clr_done = 0; clr_err = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state, R12 reset byte order
        chk("R2 rd", rd_data, 32'h0000_000E);
        chk("R2 go/busy/irq", {xfer_go, busy, irq_done, irq_err}, 4'b0000);
        chk("R12 reset", big_endian, 1'b1);

        // R3 reserved bits and field readback
        wr(32'hFFFF_FFFE);
        chk("R3 all ones", rd_data, 32'h0000_007E);
        chk("R12 big=1", big_endian, 1'b1);
        wr(32'hFFFF_FF80);
        chk("R3 reserved only", rd_data, 32'h0);
        chk("R12 big=0", big_endian, 1'b0);
        for (int v = 0; v < 64; v++) begin
            wr({25'h1FF_FFFF, v[5:0], 1'b0});
            chk("R3 field sweep", rd_data, {25'd0, v[5:0], 1'b0});
            chk("R12 sweep", big_endian, v[2]);
        end

        // R1 writing 0 to start bit leaves channel idle
        wr(cw(1, 1, 1, 0, 0, 0, 0));
        repeat (3) begin
            @(negedge clk);
            chk("R1 zero write idle", {xfer_go, busy}, 2'b00);
        end

        // R4 software transfer, R1 readback 0, R7 ext_req ignored in sw mode
        ext_req = 1'b0;
        wr(cw(1, 1, 1, 0, 1, 1, 1));
        chk("R4 go first ready cycle", {xfer_go, busy}, 2'b10);
        chk("R1 start reads 0", rd_data[0], 1'b0);
        @(negedge clk);
        chk("R4 busy after go", {xfer_go, busy}, 2'b01);
        // R1 start while active has no effect
        wr(cw(1, 1, 1, 0, 1, 1, 1));
        chk("R1 start while active", {xfer_go, busy}, 2'b01);
        strobe(1, 0, 0, 0);
        chk("R8 back to idle", {busy, irq_done, irq_err}, 3'b010);
        repeat (2) begin
            @(negedge clk);
            chk("R1 no latent arm", {xfer_go, busy}, 2'b00);
        end
        strobe(0, 0, 1, 1);

        // R8/R9 sweep of enables and completion kinds
        for (int de = 0; de < 2; de++)
            for (int ee = 0; ee < 2; ee++)
                for (int k = 0; k < 3; k++) begin
                    wr(cw(de[0], ee[0], 0, 0, 0, 0, 1));
                    @(negedge clk);
                    chk("R4 busy", busy, 1'b1);
                    strobe(k != 1, k != 0, 0, 0);
                    chk("R8/R9 idle", busy, 1'b0);
                    chk("R8 irq_done", irq_done, (k == 0) && de == 1);
                    chk("R9 irq_err", irq_err, (k != 0) && ee == 1);
                    strobe(0, 0, 1, 1);
                    chk("R11 cleared", {irq_done, irq_err}, 2'b00);
                end

        // R11 sticky flags, independent clears, set beats clear
        wr(cw(1, 1, 0, 0, 0, 0, 1)); @(negedge clk); strobe(1, 0, 0, 0);
        wr(cw(1, 1, 0, 0, 0, 0, 1)); @(negedge clk); strobe(0, 1, 0, 0);
        repeat (3) @(negedge clk);
        chk("R11 sticky", {irq_done, irq_err}, 2'b11);
        strobe(0, 0, 1, 0);
        chk("R11 clr_done only", {irq_done, irq_err}, 2'b01);
        strobe(0, 0, 0, 1);
        chk("R11 clr_err", {irq_done, irq_err}, 2'b00);
        wr(cw(1, 1, 0, 0, 0, 0, 1)); @(negedge clk);
        strobe(1, 0, 1, 0);
        chk("R11 set wins", irq_done, 1'b1);
        strobe(0, 0, 1, 1);

        // R10 strobes while idle ignored
        strobe(1, 0, 0, 0);
        chk("R10 done idle", {busy, irq_done, irq_err}, 3'b000);
        strobe(0, 1, 0, 0);
        chk("R10 err idle", {busy, irq_done, irq_err}, 3'b000);
        strobe(1, 1, 0, 0);
        chk("R10 both idle", {busy, irq_done, irq_err}, 3'b000);

        // R5/R6/R7 external request sweep over polarity and detection
        for (int p = 0; p < 2; p++)
            for (int l = 0; l < 2; l++) begin
                ext_req = ~p[0];
                wr(cw(1, 1, 0, 1, p[0], l[0], 0));
                repeat (4) @(negedge clk);
                wr(cw(1, 1, 0, 1, p[0], l[0], 1));
                repeat (3) begin
                    chk("R7 inactive no go", {xfer_go, busy}, 2'b00);
                    @(negedge clk);
                end
                ext_req = p[0];
                @(negedge clk);
                chk("R5 sync stage 1", xfer_go, 1'b0);
                @(negedge clk);
                chk("R5/R6 go after sync", {xfer_go, busy}, 2'b10);
                @(negedge clk);
                chk("R5/R6 single go", {xfer_go, busy}, 2'b01);
                strobe(1, 0, 0, 0);
                strobe(0, 0, 1, 1);
                // request held active across re-arm
                wr(cw(1, 1, 0, 1, p[0], l[0], 1));
                if (l == 1) begin
                    chk("R6 level immediate go", xfer_go, 1'b1);
                    @(negedge clk);
                    strobe(1, 0, 0, 0);
                end else begin
                    repeat (3) begin
                        chk("R5 old edge dropped", {xfer_go, busy}, 2'b00);
                        @(negedge clk);
                    end
                    ext_req = ~p[0];
                    repeat (3) @(negedge clk);
                    chk("R5 release no go", xfer_go, 1'b0);
                    ext_req = p[0];
                    @(negedge clk); @(negedge clk);
                    chk("R5 new edge go", {xfer_go, busy}, 2'b10);
                    @(negedge clk);
                    chk("R5 new edge single", {xfer_go, busy}, 2'b01);
                    strobe(1, 0, 0, 0);
                end
                ext_req = ~p[0];
                strobe(0, 0, 1, 1);
                repeat (3) @(negedge clk);
            end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule